// File: doc/BRIEF.md
# Geographic Address Decoder

This block sits between a 64-bit processor and the resources it can reach. It looks at the upper bits of each address. They show whether the access stays on the local card or has to leave through a backplane expansion slot. For a local access, it picks one of sixteen on-card devices. The top nibble names a card. The next nibble names a device on that card. The remaining 56 bits are an offset inside that device.

Card codes zero and fifteen always mean "this card". Software running straight out of reset therefore reaches the boot image without knowing which slot holds the card. When the card is plugged into slot N, code N also means "this card". Any other code becomes a backplane request that carries the code. A local access outside the implemented devices, or outside a device's implemented size, raises an error flag. The decoder is purely combinational. With the valid strobe low, all of its outputs are zero.

Top module: `geo_addr_decode`

## Requirements
- R1: The card code is address bits 63:60 and the device number is bits 59:56. On a selected local device, `dev_off` carries address bits 55:0. In every other case it is zero.
- R2: Card codes 0x0 and 0xF decode as local for every value of `slot_id`.
- R3: When `slot_id` is between 1 and 14, a card code equal to `slot_id` decodes as local.
- R4: When `slot_id` is 0, only codes 0x0 and 0xF decode as local.
- R5: A non-local code raises `bp_req`, places the code on `bp_card`, and leaves `dev_sel` and `map_err` low. `bp_card` is zero whenever `bp_req` is low.
- R6: Device 0 is the boot ROM and spans offsets 0x0 to 0x3FFF. A read in that range sets `dev_sel[0]`, and this includes the reset fetch at 0x2000.
- R7: Device 1 is RAM and spans offsets 0x0 to 0xFFFFFF. An access in that range sets `dev_sel[1]`.
- R8: Device 0xF is the debug console and spans offsets 0x0 to 0xF. An access in that range sets `dev_sel[15]`.
- R9: A local access sets `map_err` with `dev_sel` zero in two cases: it targets a device from 2 to 14, or its offset is at or past the size of the targeted device.
- R10: A write (`wr`=1) to the boot ROM sets `map_err` and selects no device.
- R11: With `valid` low, `dev_sel`, `dev_off`, `bp_req`, `bp_card` and `map_err` are all zero.
- R12: With `valid` high, exactly one of these is active: a single bit of `dev_sel`, `bp_req`, or `map_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid | input | 1 | Address strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 64 | Processor byte address |
| slot_id | input | 4 | Backplane slot of this card, 0 when unplugged |
| dev_sel | output | 16 | One-hot local device select |
| dev_off | output | 56 | Offset inside the selected device |
| bp_req | output | 1 | Access goes to the backplane |
| bp_card | output | 4 | Target card code for the backplane |
| map_err | output | 1 | Unmapped local access |

## Verification
The immediate assertions hold at every input change. They check four things: the three outcomes exclude one another, any selected device matches the address's device nibble, `bp_card` agrees with the address whenever a request is raised, and everything is quiet while the strobe is low. Some behaviour only the bench's sweep can show: which codes count as local for a given slot number, where each device window ends, and how ROM writes are refused. The sweep runs over every card and device code, under unplugged, low-slot and high-slot settings, with offsets on both sides of each window edge.

// File: rtl/gad_pkg.sv
package gad_pkg;
  localparam int ADDR_W = 64;
  localparam int CARD_W = 4;
  localparam int DEV_W  = 4;
  localparam int OFF_W  = ADDR_W - CARD_W - DEV_W;
  localparam int NDEV   = 1 << DEV_W;

  // True when offset fits in a window of 2**aw bytes
  function automatic logic in_window(input logic [OFF_W-1:0] off, input int aw);
    logic [OFF_W-1:0] mask;
    mask = (aw >= OFF_W) ? '1 : ((OFF_W'(1) << aw) - OFF_W'(1));
    return (off & ~mask) == '0;
  endfunction

  // Card code that means "this card" in every slot
  function automatic logic is_self_code(input logic [CARD_W-1:0] card);
    return (card == '0) || (card == '1);
  endfunction
endpackage

// File: rtl/gad_card_match.sv
module gad_card_match
  import gad_pkg::*;
(
  input  logic [CARD_W-1:0] card,
  input  logic [CARD_W-1:0] slot,
  output logic              is_local
);
  logic slot_plugged;
  logic slot_hit;

  always_comb begin
    slot_plugged = (slot != '0);
    slot_hit     = slot_plugged && (card == slot);
    is_local     = is_self_code(card) || slot_hit;
  end
endmodule

// File: rtl/gad_dev_window.sv
module gad_dev_window
  import gad_pkg::*;
#(
  parameter int ROM_AW = 14,
  parameter int RAM_AW = 24,
  parameter int CON_AW = 4
) (
  input  logic [DEV_W-1:0] dev,
  input  logic [OFF_W-1:0] off,
  input  logic             wr,
  output logic [NDEV-1:0]  hit_vec
);
  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    localparam int AW = (i == 0) ? ROM_AW :
                        (i == 1) ? RAM_AW :
                        (i == NDEV-1) ? CON_AW : -1;
    localparam bit IMPL = (AW >= 0);
    localparam bit RO   = (i == 0);
    logic addr_hit;
    always_comb begin
      addr_hit   = (dev == DEV_W'(i)) && IMPL && in_window(off, AW);
      hit_vec[i] = addr_hit && !(RO && wr);
    end
  end
endmodule

// File: rtl/geo_addr_decode.sv
module geo_addr_decode
  import gad_pkg::*;
#(
  parameter int ROM_AW = 14,
  parameter int RAM_AW = 24,
  parameter int CON_AW = 4
) (
  input  logic        valid,
  input  logic        wr,
  input  logic [63:0] addr,
  input  logic [3:0]  slot_id,
  output logic [15:0] dev_sel,
  output logic [55:0] dev_off,
  output logic        bp_req,
  output logic [3:0]  bp_card,
  output logic        map_err
);
  logic [CARD_W-1:0] card_code;
  logic [DEV_W-1:0]  dev_code;
  logic [OFF_W-1:0]  off_field;
  logic              card_local;
  logic [NDEV-1:0]   win_hit;
  logic              local_ok;

  assign card_code = addr[ADDR_W-1 -: CARD_W];
  assign dev_code  = addr[OFF_W +: DEV_W];
  assign off_field = addr[OFF_W-1:0];

  gad_card_match u_card (
    .card(card_code), .slot(slot_id), .is_local(card_local)
  );

  gad_dev_window #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .CON_AW(CON_AW)) u_win (
    .dev(dev_code), .off(off_field), .wr(wr), .hit_vec(win_hit)
  );

  always_comb begin
    local_ok = valid && card_local && (win_hit != '0);
    dev_sel  = local_ok ? win_hit : '0;
    dev_off  = local_ok ? off_field : '0;
    bp_req   = valid && !card_local;
    bp_card  = bp_req ? card_code : '0;
    map_err  = valid && card_local && (win_hit == '0);
  end

  always_comb begin
    assert_sel_onehot_R12: assert ($onehot0(dev_sel));
    if (valid) begin
      assert_one_outcome_R12: assert ($countones({dev_sel != '0, bp_req, map_err}) == 1);
    end else begin
      assert_idle_quiet_R11: assert (dev_sel == '0 && !bp_req && !map_err && bp_card == '0 && dev_off == '0);
    end
    if (dev_sel != '0) begin
      assert_sel_matches_dev_R1: assert (dev_sel == (NDEV'(1) << addr[59:56]));
    end
    if (bp_req) begin
      assert_bp_card_match_R5: assert (bp_card == addr[63:60] && addr[63:60] != 4'h0 && addr[63:60] != 4'hF);
      assert_bp_not_own_R3: assert (slot_id == 4'h0 || addr[63:60] != slot_id);
    end
    if (dev_sel[0]) begin
      assert_rom_read_only_R10: assert (!wr);
    end
  end
endmodule

// File: tb/geo_addr_decode_tb.sv
module geo_addr_decode_tb;
  logic        clk = 1'b0;
  logic        valid, wr;
  logic [63:0] addr;
  logic [3:0]  slot_id;
  logic [15:0] dev_sel;
  logic [55:0] dev_off;
  logic        bp_req;
  logic [3:0]  bp_card;
  logic        map_err;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  geo_addr_decode u_dut (
    .valid(valid), .wr(wr), .addr(addr), .slot_id(slot_id),
    .dev_sel(dev_sel), .dev_off(dev_off), .bp_req(bp_req),
    .bp_card(bp_card), .map_err(map_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s addr=%h slot=%0d wr=%0d actual=%h expected=%h", req, addr, slot_id, wr, act, exp);
    end
  endtask

  function automatic logic [55:0] dev_size(input int d);
    case (d)
      0:  return 56'h4000;
      1:  return 56'h100_0000;
      15: return 56'h10;
      default: return 56'h0;
    endcase
  endfunction

  task automatic apply(input logic v, input logic w, input logic [63:0] a, input logic [3:0] s);
    @(negedge clk);
    valid = v; wr = w; addr = a; slot_id = s;
    #5;
  endtask

  task automatic sweep_one(input int s, input int c, input int d, input logic [55:0] off, input logic w);
    bit loc, hit;
    string rq;
    logic [15:0] e_sel;
    apply(1'b1, w, {c[3:0], d[3:0], off}, s[3:0]);
    loc = (c == 0) || (c == 15) || (s != 0 && c == s);
    hit = loc && (off < dev_size(d)) && !(d == 0 && w);
    e_sel = hit ? (16'h1 << d) : 16'h0;
    if (!loc) rq = (s == 0) ? "R4/R5" : "R5";
    else if (c == s && s != 0) rq = "R3";
    else if (!hit && d == 0 && w && off < 56'h4000) rq = "R10";
    else if (!hit) rq = "R9";
    else if (d == 0) rq = "R6";
    else if (d == 1) rq = "R7";
    else rq = "R8";
    if (loc && !(c == s && s != 0)) rq = {rq, "/R2"};
    check(dev_sel == e_sel, rq, 64'(dev_sel), 64'(e_sel));
    check(bp_req == !loc, rq, 64'(bp_req), 64'(!loc));
    check(bp_card == (loc ? 4'h0 : c[3:0]), rq, 64'(bp_card), 64'(loc ? 4'h0 : c[3:0]));
    check(map_err == (loc && !hit), {rq, "/R12"}, 64'(map_err), 64'(loc && !hit));
    check(dev_off == (hit ? off : 56'h0), "R1", 64'(dev_off), 64'(hit ? off : 56'h0));
  endtask

  initial begin
    int slots[3] = '{0, 3, 14};
    valid = 0; wr = 0; addr = '0; slot_id = '0;
    // R11: idle outputs at start and with a busy address
    apply(1'b0, 1'b0, 64'h0, 4'h0);
    check(dev_sel == 0 && !bp_req && !map_err && bp_card == 0 && dev_off == 0, "R11", 64'(dev_sel), 64'h0);
    apply(1'b0, 1'b1, 64'h5F00_0000_0000_0003, 4'h5);
    check(dev_sel == 0 && !bp_req && !map_err && bp_card == 0 && dev_off == 0, "R11", 64'(bp_req), 64'h0);
    // R6: reset fetch through both self codes
    apply(1'b1, 1'b0, 64'h0000_0000_0000_2000, 4'h7);
    check(dev_sel == 16'h1 && dev_off == 56'h2000, "R6", 64'(dev_sel), 64'h1);
    apply(1'b1, 1'b0, 64'hF000_0000_0000_2000, 4'h0);
    check(dev_sel == 16'h1, "R6/R2", 64'(dev_sel), 64'h1);
    foreach (slots[k]) begin
      for (int c = 0; c < 16; c++) begin
        for (int d = 0; d < 16; d++) begin
          logic [55:0] sz;
          sz = dev_size(d);
          for (int w = 0; w < 2; w++) begin
            sweep_one(slots[k], c, d, 56'h0, w[0]);
            sweep_one(slots[k], c, d, 56'hFF_FFFF_FFFF_FFFF, w[0]);
            if (sz != 0) begin
              sweep_one(slots[k], c, d, sz - 56'h1, w[0]);
              sweep_one(slots[k], c, d, sz, w[0]);
            end
          end
        end
      end
    end
    apply(1'b0, 1'b0, 64'h0F00_0000_0000_0001, 4'h0);
    check(dev_sel == 0 && dev_off == 0, "R11", 64'(dev_sel), 64'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule